// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts the rendering lines of a picture processor by watching one of its address lines. Every qualified rising edge of that line steps an 8-bit down-counter. When the counter reloads from a value latched by the CPU, or steps down to zero, while interrupts are enabled, an interrupt request is raised to the CPU. The request does not appear at once. It waits a fixed number of CPU cycles, two by default, and then stays high until software acknowledges it.

The CPU programs the block through four write-only locations. The decode mask 0xE001 picks them out of the upper CPU address space. 0xC000 latches the reload value. 0xC001 zeroes the counter and arms a forced reload. 0xE000 acknowledges and disables. 0xE001 enables. The raw address line is synchronised first. It is then qualified by a low-time filter counted in CPU cycles, so the fast toggling during pattern fetches does not count as line edges. One clock drives the block. A CPU-cycle enable marks the cycles used by the filter and by the delay.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset, irq is low, interrupts are disabled, and both the counter and the reload value are zero. So enabling and then giving one qualified edge raises irq.
- R2: A write whose address ANDed with 0xE001 equals 0xC000 latches the reload value. A write that decodes to 0xC001 zeroes the counter and forces a reload on the next qualified edge.
- R3: On a qualified edge, a counter that is nonzero with no forced reload pending decrements by one. A reload value N > 0 therefore raises irq on the (N+1)th edge after a 0xC001 write.
- R4: On a qualified edge, a counter at zero loads the reload value. With a reload value of 0, every qualified edge leaves the count at zero.
- R5: When the count is zero after an edge update and interrupts are enabled, irq rises exactly at the second cpu_ce cycle that follows. It does not rise before then.
- R6: While interrupts are disabled, a count of zero does not raise irq.
- R7: A write decoding to 0xE000 clears irq and cancels a delay in progress. A write decoding to 0xE001 enables interrupts.
- R8: Once raised, irq stays high through further edges and other writes until a 0xE000 write or reset.
- R9: A rising edge of ppu_a12 is counted only if the synchronised line was low for at least LOW_MIN (default 3) cpu_ce cycles before it.
- R10: Address bits outside the mask 0xE001 are ignored, so 0xDFFE acts as 0xC000 and 0xC003 acts as 0xC001. Writes decoding to 0x8000, 0x8001, 0xA000 or 0xA001 have no effect on this block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | High for one clk per CPU cycle |
| wr_en | input | 1 | CPU write strobe, one clk |
| wr_addr | input | ADDR_W | CPU write address |
| wr_data | input | DATA_W | CPU write data |
| ppu_a12 | input | 1 | Raw picture-processor address line |
| irq | output | 1 | Active-high interrupt request level |

## Verification
The hardest case to set up from the ports is the exact position of the interrupt inside the delay window. The counter update and the CPU-cycle delay run on different events, so the stimulus holds cpu_ce low after a qualified edge. It then gives single CPU cycles one at a time and samples irq between them. The same freeze is used to place an acknowledge inside the window, which shows that the pending request is cancelled. For the filter, a short low pulse is placed just before a full edge sequence. If the short pulse were counted, the interrupt would arrive one edge early.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

   // Register location selected by a CPU write after masking
   typedef enum logic [2:0] {
      LOC_NONE   = 3'd0,
      LOC_LATCH  = 3'd1,
      LOC_RESTRT = 3'd2,
      LOC_ACK    = 3'd3,
      LOC_ARM    = 3'd4
   } loc_sel_t;

   localparam logic [15:0] DEC_MASK  = 16'hE001;
   localparam logic [15:0] A_LATCH   = 16'hC000;
   localparam logic [15:0] A_RESTART = 16'hC001;
   localparam logic [15:0] A_ACK     = 16'hE000;
   localparam logic [15:0] A_ARM     = 16'hE001;

   function automatic loc_sel_t decode_loc(input logic [15:0] addr);
      logic [15:0] m;
      m = addr & DEC_MASK;
      case (m)
         A_LATCH:   decode_loc = LOC_LATCH;
         A_RESTART: decode_loc = LOC_RESTRT;
         A_ACK:     decode_loc = LOC_ACK;
         A_ARM:     decode_loc = LOC_ARM;
         default:   decode_loc = LOC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/a12_edge_filter.sv
module a12_edge_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int LOW_MIN     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_ce,
   input  logic a12_raw,
   output logic rise
);
   localparam int LW = (LOW_MIN < 1) ? 1 : $clog2(LOW_MIN + 1);

   logic a12_s;
   logic prev_q;

   // Synchroniser: depth chosen by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign a12_s = a12_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= a12_raw;
         end
         for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
         assign a12_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= a12_s;
   end

   // Low-time qualifier
   generate
      if (LOW_MIN == 0) begin : g_nofilt
         assign rise = a12_s & ~prev_q;
      end else begin : g_filt
         logic [LW-1:0] low_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               low_q <= '0;
            end else if (a12_s) begin
               low_q <= '0;
            end else if (cpu_ce && (low_q != LW'(LOW_MIN))) begin
               low_q <= low_q + 1'b1;
            end
         end
         assign rise = a12_s & ~prev_q & (low_q == LW'(LOW_MIN));
      end
   endgenerate

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import scanline_irq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  reload_val,
   output logic              irq_en,
   output logic              restart,
   output logic              ack
);
   loc_sel_t sel;

   always_comb begin
      sel = LOC_NONE;
      if (wr_en) sel = decode_loc(wr_addr[15:0]);
   end

   assign restart = (sel == LOC_RESTRT);
   assign ack     = (sel == LOC_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_val <= '0;
         irq_en     <= 1'b0;
      end else begin
         if (sel == LOC_LATCH) reload_val <= wr_data[CNT_W-1:0];
         if (sel == LOC_ACK)      irq_en <= 1'b0;
         else if (sel == LOC_ARM) irq_en <= 1'b1;
      end
   end

endmodule

// File: rtl/line_counter.sv
module line_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             restart,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             irq_en,
   output logic [CNT_W-1:0] cnt_q,
   output logic             fire
);
   logic             pend_q;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      if ((cnt_q == '0) || pend_q) cnt_nxt = reload_val;
      else                         cnt_nxt = cnt_q - 1'b1;
   end

   // A restart write in the same clk wins over the edge
   assign fire = rise & ~restart & irq_en & (cnt_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (restart) begin
         cnt_q  <= '0;
         pend_q <= 1'b1;
      end else if (rise) begin
         cnt_q  <= cnt_nxt;
         pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_delay.sv
module irq_delay #(
   parameter int IRQ_DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_ce,
   input  logic fire,
   input  logic ack,
   output logic irq
);
   localparam int DW = (IRQ_DELAY < 1) ? 1 : $clog2(IRQ_DELAY + 1);

   generate
      if (IRQ_DELAY == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    irq <= 1'b0;
            else if (ack)  irq <= 1'b0;
            else if (fire) irq <= 1'b1;
         end
      end else begin : g_timed
         logic [DW-1:0] dly_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dly_q <= '0;
               irq   <= 1'b0;
            end else if (ack) begin
               dly_q <= '0;
               irq   <= 1'b0;
            end else if (fire) begin
               dly_q <= DW'(IRQ_DELAY);
            end else if (cpu_ce && (dly_q != '0)) begin
               dly_q <= dly_q - 1'b1;
               if (dly_q == DW'(1)) irq <= 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 8,
   parameter int LOW_MIN     = 3,
   parameter int SYNC_STAGES = 2,
   parameter int IRQ_DELAY   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_ce,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ppu_a12,
   output logic              irq
);
   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("scanline_irq_unit: ADDR_W must be at least 16");
      end
      if (DATA_W < CNT_W) begin : g_bad_data
         $error("scanline_irq_unit: DATA_W must cover CNT_W");
      end
      if (CNT_W < 1 || LOW_MIN < 0 || SYNC_STAGES < 0 || IRQ_DELAY < 0) begin : g_bad_par
         $error("scanline_irq_unit: illegal parameter value");
      end
   endgenerate

   logic             a12_rise;
   logic [CNT_W-1:0] reload_val;
   logic             irq_en;
   logic             restart;
   logic             ack;
   logic [CNT_W-1:0] cnt_q;
   logic             fire;

   a12_edge_filter #(.SYNC_STAGES(SYNC_STAGES), .LOW_MIN(LOW_MIN)) filt_i (
      .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .a12_raw(ppu_a12), .rise(a12_rise)
   );

   irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dec_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .reload_val(reload_val), .irq_en(irq_en), .restart(restart), .ack(ack)
   );

   line_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .rise(a12_rise), .restart(restart),
      .reload_val(reload_val), .irq_en(irq_en), .cnt_q(cnt_q), .fire(fire)
   );

   irq_delay #(.IRQ_DELAY(IRQ_DELAY)) dly_i (
      .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .fire(fire), .ack(ack), .irq(irq)
   );

endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ce,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              irq,
   input logic              a12_rise,
   input logic              restart,
   input logic [CNT_W-1:0]  cnt_q
);
   logic ack_wr;
   assign ack_wr = wr_en && ((wr_addr[15:0] & 16'hE001) == 16'hE000);

   // R7
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> !irq);

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack_wr) |=> irq);

   // R5
   irq_on_cpu_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(cpu_ce));

   // R2
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

   // R9
   single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a12_rise |=> !a12_rise);

endmodule

bind scanline_irq_unit scanline_irq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en), .wr_addr(wr_addr),
   .irq(irq), .a12_rise(a12_rise), .restart(restart), .cnt_q(cnt_q)
);

// File: tb/scanline_irq_unit_tb_top.sv
`timescale 1ns/1ps
module scanline_irq_unit_tb_top;
   localparam int LOW_MIN = 3;
   localparam int NVEC    = 6;
   // each entry: {reload value, edge number at which irq must rise}
   localparam logic [15:0] VEC [NVEC] = '{
      {8'd0, 8'd1}, {8'd1, 8'd2}, {8'd2, 8'd3},
      {8'd5, 8'd6}, {8'd7, 8'd8}, {8'd3, 8'd4}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_ce = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        ppu_a12 = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   scanline_irq_unit #(.LOW_MIN(LOW_MIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ppu_a12(ppu_a12), .irq(irq)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: irq=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ce_tick();
      @(negedge clk); cpu_ce = 1'b1;
      @(negedge clk); cpu_ce = 1'b0;
   endtask

   // Qualified edge; leaves the counter updated and the delay untouched
   task automatic a12_edge(input int low_ticks);
      @(negedge clk); ppu_a12 = 1'b0;
      repeat (low_ticks) ce_tick();
      @(negedge clk); ppu_a12 = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic good_edge();
      a12_edge(LOW_MIN + 3);
      repeat (3) ce_tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 reset irq", irq, 1'b0);
      wr(16'hE001, 8'h00);
      good_edge();
      check("R1 zero count and reload fire on first edge", irq, 1'b1);

      // R2 R3 R4 R5: table walk
      for (int v = 0; v < NVEC; v++) begin
         logic [7:0] rl, at;
         {rl, at} = VEC[v];
         wr(16'hE000, 8'h00);
         wr(16'hE001, 8'h00);
         wr(16'hC000, rl);
         wr(16'hC001, 8'h00);
         for (int k = 1; k <= at; k++) begin
            good_edge();
            check("R3 R4 table edge", irq, (k == at));
         end
      end

      // R5: exact delay
      wr(16'hE000, 8'h00); wr(16'hE001, 8'h00);
      wr(16'hC000, 8'h00); wr(16'hC001, 8'h00);
      a12_edge(LOW_MIN + 3);
      check("R5 no irq without cpu cycle", irq, 1'b0);
      ce_tick();
      check("R5 no irq after one cycle", irq, 1'b0);
      ce_tick();
      check("R5 irq after two cycles", irq, 1'b1);

      // R8: stays high through edges and other writes
      good_edge();
      wr(16'h8000, 8'hFF); wr(16'hA000, 8'h01);
      check("R8 irq held", irq, 1'b1);

      // R7: acknowledge clears
      wr(16'hE000, 8'h00);
      check("R7 ack clears irq", irq, 1'b0);

      // R6: disabled, zero count
      wr(16'hC001, 8'h00);
      good_edge(); good_edge();
      check("R6 no irq while disabled", irq, 1'b0);

      // R7: ack cancels an armed delay
      wr(16'hE001, 8'h00); wr(16'hC001, 8'h00);
      a12_edge(LOW_MIN + 3);
      wr(16'hE000, 8'h00);
      repeat (3) ce_tick();
      check("R7 ack cancels pending delay", irq, 1'b0);

      // R9: short low pulse ignored
      wr(16'hE001, 8'h00);
      wr(16'hC000, 8'h01); wr(16'hC001, 8'h00);
      a12_edge(1);
      repeat (3) ce_tick();
      good_edge();
      check("R9 short pulse not counted", irq, 1'b0);
      good_edge();
      check("R9 irq on second full edge", irq, 1'b1);

      // R10: mirrored locations and foreign writes
      wr(16'hE000, 8'h00); wr(16'hE001, 8'h00);
      wr(16'hDFFE, 8'h02); wr(16'hC003, 8'h00);
      wr(16'h8001, 8'h00); wr(16'hA001, 8'hFF);
      good_edge();
      check("R10 mirror edge 1", irq, 1'b0);
      good_edge();
      check("R10 mirror edge 2", irq, 1'b0);
      good_edge();
      check("R10 mirror edge 3 fires", irq, 1'b1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual running expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule